// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a clocked requester and a 32K x 8 asynchronous static RAM with active-low chip, write and output enables. A requester presents one byte-wide read or write with an address. The controller takes it only while idle, then produces the strobe pattern the memory needs. Every minimum time (access, pulse width, setup, bus release, cycle length) is turned into a whole number of clock cycles by parameters derived from the clock period.

The bidirectional data bus is split into an output byte, an input byte and a drive enable. Writes are made by overlapping chip enable and write enable, with output enable held high. Reads hold chip enable and output enable low for the full access window and register the returned byte on the last cycle of that window. Between operations the memory sits in standby with chip enable high. After a read, a turnaround gap lets the memory release the bus before the controller can drive it again.

Top module: `async_sram_ctrl`

## Requirements
- R1: After reset and whenever no operation is in progress, mem_ce_n, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0 and req_ready is 1.
- R2: A request is taken only on a clock edge where req_valid and req_ready are both 1. req_ready is 0 from that edge until the operation's recovery ends, and req_valid has no effect during that time.
- R3: mem_addr changes only on an edge where mem_ce_n and mem_we_n are 1 both before and after it. One setup cycle with every strobe high follows each accepted request.
- R4: A read (req_write = 0) holds mem_ce_n and mem_oe_n at 0 and mem_we_n at 1 for RD_CYC = max(ceil(T_AA/CLK_NS), ceil(T_OE/CLK_NS)) cycles. That is 14 cycles at the defaults (4 ns clock, 55 ns and 30 ns).
- R5: The read byte is sampled from mem_dq_in on the edge that ends the read window, where ce and oe rise. rsp_valid is 1 for exactly the next cycle, with that byte on rsp_rdata.
- R6: A write (req_write = 1) holds mem_ce_n and mem_we_n at 0 for WR_CYC = ceiling of the largest of T_WP, T_AW, T_CW and T_DW over CLK_NS. That is 13 cycles at the defaults. mem_oe_n stays 1 throughout, and req_wdata is on mem_dq_out, stable, with mem_dq_oe = 1.
- R7: mem_dq_oe falls on the same edge where mem_we_n rises, and it is 1 only while mem_we_n is 0.
- R8: After a read window, all strobes stay high and the bus stays undriven for max(ceil(T_HZ/CLK_NS), ceil(T_RC/CLK_NS) - RD_CYC - 1, 1) cycles before req_ready returns. That is 5 cycles at the defaults.
- R9: After a write pulse, rsp_valid pulses once. The block recovers for max(ceil(T_WC/CLK_NS) - WR_CYC - 1, 1) cycles, which is 1 at the defaults, before req_ready returns.
- R10: Data written to an address is returned by a later read of it. This holds for the lowest and highest addresses and for back-to-back read/write alternation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Controller idle, request taken this edge if valid |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte captured by the last read |
| mem_addr | output | 15 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Byte driven onto the data bus |
| mem_dq_in | input | 8 | Byte read from the data bus |
| mem_dq_oe | output | 1 | Controller drives the data bus |

## Verification
A wrong state or a cycle counter off by one shows up at the ports on the very next cycle. A strobe edge moves, or req_ready or rsp_valid appears one cycle early or late, so the bench's per-cycle timeline model catches it at once. A capture taken too early picks up the bus-model filler byte instead of stored data. A drive enable that lingers or starts early meets the model's bus-release clock and is flagged as contention. An address that moves under a low strobe is flagged in the cycle it moves.

// File: rtl/async_sram_ctrl.sv
`timescale 1ns/1ps
module async_sram_ctrl #(
  parameter int CLK_NS = 4,
  parameter int T_RC   = 55,
  parameter int T_AA   = 55,
  parameter int T_OE   = 30,
  parameter int T_WC   = 55,
  parameter int T_WP   = 45,
  parameter int T_AW   = 50,
  parameter int T_CW   = 50,
  parameter int T_DW   = 25,
  parameter int T_HZ   = 20,
  parameter int AW     = 15,
  parameter int DW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  input  logic [DW-1:0] mem_dq_in,
  output logic          mem_dq_oe
);
  function automatic int cyc(input int t);
    return (t <= 0) ? 0 : (t + CLK_NS - 1) / CLK_NS;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_CYC = mx(mx(cyc(T_AA), cyc(T_OE)), 1);
  localparam int WR_CYC = mx(mx(mx(cyc(T_WP), cyc(T_AW)), mx(cyc(T_CW), cyc(T_DW))), 1);
  localparam int RD_TA  = mx(mx(cyc(T_HZ), cyc(T_RC) - RD_CYC - 1), 1);
  localparam int WR_REC = mx(cyc(T_WC) - WR_CYC - 1, 1);
  localparam int CNT_MAX = mx(mx(RD_CYC, WR_CYC), mx(RD_TA, WR_REC));
  localparam int CW = $clog2(CNT_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_RD, S_WR, S_REC} state_t;
  state_t st;
  logic [CW-1:0] cnt;
  logic op_wr;

  assign req_ready = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      op_wr <= 1'b0;
      mem_addr <= '0;
      mem_dq_out <= '0;
      mem_ce_n <= 1'b1;
      mem_we_n <= 1'b1;
      mem_oe_n <= 1'b1;
      mem_dq_oe <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st)
        S_IDLE: if (req_valid) begin
          mem_addr <= req_addr;
          mem_dq_out <= req_wdata;
          op_wr <= req_write;
          st <= S_SETUP;
        end
        S_SETUP: begin
          mem_ce_n <= 1'b0;
          if (op_wr) begin
            mem_we_n <= 1'b0;
            mem_dq_oe <= 1'b1;
            cnt <= CW'(WR_CYC - 1);
            st <= S_WR;
          end else begin
            mem_oe_n <= 1'b0;
            cnt <= CW'(RD_CYC - 1);
            st <= S_RD;
          end
        end
        S_RD: if (cnt == '0) begin
          rsp_rdata <= mem_dq_in;
          mem_ce_n <= 1'b1;
          mem_oe_n <= 1'b1;
          rsp_valid <= 1'b1;
          cnt <= CW'(RD_TA - 1);
          st <= S_REC;
        end else cnt <= cnt - 1'b1;
        S_WR: if (cnt == '0) begin
          mem_ce_n <= 1'b1;
          mem_we_n <= 1'b1;
          mem_dq_oe <= 1'b0;
          rsp_valid <= 1'b1;
          cnt <= CW'(WR_REC - 1);
          st <= S_REC;
        end else cnt <= cnt - 1'b1;
        S_REC: if (cnt == '0) st <= S_IDLE;
               else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R6
  oe_high_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);
  // R7
  drive_only_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_we_n && !mem_ce_n);
  // R3
  addr_move_strobes_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_addr) |-> mem_ce_n && mem_we_n && $past(mem_ce_n) && $past(mem_we_n));
  // R5
  rsp_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  // R6
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe && $past(mem_dq_oe) |-> $stable(mem_dq_out));
endmodule

// File: tb/async_sram_ctrl_tb.sv
`timescale 1ns/1ps
module async_sram_ctrl_tb_top;
  localparam int P = 4;
  localparam int N_RD = ((55 + P - 1) / P > (30 + P - 1) / P) ? (55 + P - 1) / P : (30 + P - 1) / P;
  localparam int N_WR = (50 + P - 1) / P;
  localparam int T_RD = 5;
  localparam int T_WR = 1;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [14:0] req_addr = 0;
  logic [7:0] req_wdata = 0;
  logic req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0] rsp_rdata, mem_dq_out;
  logic [7:0] mem_dq_in = 8'h5A;
  logic [14:0] mem_addr;

  async_sram_ctrl dut_i (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe));

  always #2 clk = ~clk;

  int tests = 0, fails = 0;
  bit finished = 0;
  logic [7:0] mem [int];
  logic [7:0] sb [int];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // cycle model of the expected timeline
  bit busy = 0, m_wr = 0;
  int k = 0;
  logic [14:0] m_addr;
  always @(posedge clk) if (rst_n) begin
    if (busy) k++;
    else if (req_valid) begin busy = 1; k = 0; m_wr = req_write; m_addr = req_addr; end
  end

  always @(negedge clk) if (rst_n) begin
    if (!busy) begin
      chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 idle strobes",
          {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
      chk(req_ready, "R1 idle ready", req_ready, 1);
    end else begin
      int n, t;
      bit win;
      n = m_wr ? N_WR : N_RD;
      t = m_wr ? T_WR : T_RD;
      win = (k >= 1) && (k <= n);
      chk(mem_ce_n == !win, m_wr ? "R6 ce window" : "R4 ce window", mem_ce_n, !win);
      chk(mem_we_n == !(m_wr && win), m_wr ? "R6 we window" : "R4 we high", mem_we_n, !(m_wr && win));
      chk(mem_oe_n == !(!m_wr && win), m_wr ? "R6 oe high" : "R4 oe window", mem_oe_n, !(!m_wr && win));
      chk(mem_dq_oe == (m_wr && win), "R7 drive enable", mem_dq_oe, m_wr && win);
      chk(rsp_valid == (k == n + 1), m_wr ? "R9 write done pulse" : "R5 read pulse", rsp_valid, k == n + 1);
      chk(req_ready == (k == n + t + 1), m_wr ? "R9 recovery" : "R8 turnaround", req_ready, k == n + t + 1);
      if (k >= 1) chk(mem_addr == m_addr, "R2 address held", mem_addr, m_addr);
      if (k == n + 1 && !m_wr)
        chk(rsp_rdata == (sb.exists(m_addr) ? sb[m_addr] : 8'h00), "R10 read data", rsp_rdata,
            sb.exists(m_addr) ? sb[m_addr] : 8'h00);
      if (k == n + t + 1) busy = 0;
    end
  end

  // behavioural asynchronous memory
  logic [14:0] p_addr = 0;
  logic p_ce = 1, p_we = 1, p_oe = 1;
  int wlen = 0;
  logic [7:0] wdat;
  realtime t_rd_start = 0, t_release = -100;
  always @(negedge clk) if (rst_n) begin
    bit rd_on;
    if (mem_addr != p_addr)
      chk(p_ce && p_we && mem_ce_n && mem_we_n, "R3 addr moved under strobe",
          {p_ce, p_we, mem_ce_n, mem_we_n}, 4'hF);
    if (!mem_ce_n && !mem_we_n) begin
      if (wlen > 0) chk(mem_dq_out == wdat, "R6 write data stable", mem_dq_out, wdat);
      chk(mem_dq_oe, "R6 bus driven in pulse", mem_dq_oe, 1);
      wdat = mem_dq_out;
      wlen++;
    end else if (wlen > 0) begin
      mem[int'(p_addr)] = wdat;
      chk(wlen * P >= 50, "R6 write pulse width", wlen * P, 50);
      wlen = 0;
    end
    rd_on = !mem_ce_n && !mem_oe_n && mem_we_n;
    if (rd_on && (p_ce || p_oe)) t_rd_start = $realtime - 2;
    if (!rd_on && !p_ce && !p_oe && p_we) t_release = $realtime - 2 + 20;
    if (mem_dq_oe)
      chk(!rd_on && $realtime >= t_release, "R8 bus contention", mem_dq_oe, 0);
    if (rd_on && ($realtime + 2 - t_rd_start) >= 55)
      mem_dq_in <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
    else mem_dq_in <= 8'h5A;
    p_addr = mem_addr; p_ce = mem_ce_n; p_we = mem_we_n; p_oe = mem_oe_n;
  end

  task automatic op(input bit wr, input logic [14:0] a, input logic [7:0] d);
    while (busy || !req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    if (wr) sb[int'(a)] = d;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready, "R1 reset state",
        {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready}, 5'b11101);
    rst_n = 1;
    @(negedge clk);
    op(1, 15'h0000, 8'h3C);
    op(1, 15'h7FFF, 8'hC3);
    op(1, 15'h1234, 8'hA7);
    op(0, 15'h0000, 0);
    op(0, 15'h7FFF, 0);
    op(0, 15'h1234, 0);
    op(0, 15'h0101, 0);
    // R2: a request raised while busy is ignored
    op(0, 15'h1234, 0);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 15'h1234; req_wdata = 8'hFF;
    @(negedge clk);
    req_valid = 0;
    op(0, 15'h1234, 0);
    for (int i = 0; i < 6; i++) begin
      op(1, 15'(i * 4099), 8'(i * 37 + 5));
      op(0, 15'(i * 4099), 0);
    end
    op(1, 15'h7FFF, 8'h00);
    op(0, 15'h7FFF, 0);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    finished = 1;
  end

  initial begin
    int cyc = 0;
    while (!finished && cyc < 200000) begin @(posedge clk); cyc++; end
    if (!finished) chk(0, "watchdog", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule